// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block is a 38-cell serial command chain. A debugger uses it to read and write a bank of on-chip debug registers over a test clock. Each frame holds three fields: a direction bit, a 5-bit register index and a 32-bit data word. The frame is shifted in while the TAP controller asserts its shift strobe. When the update strobe arrives, the block decodes the frame. A write frame copies the data word into the indexed register. A read frame replaces the data field of the chain with the indexed register's contents, and the debugger collects that value on the next shift pass.

The capture strobe is accepted but deliberately changes nothing, so a value loaded by a read survives the capture that a normal TAP walk performs before shifting. The chain responds only while a chain-select input and an internal-test indication are both high. Both signals, and all strobes, come from an external TAP controller. The number of implemented registers is a parameter. Indices above the implemented range read back as zero and ignore writes.

Top module: `dbg_regscan`

## Requirements
- R1: The serial path from `tdi` to `tdo` is exactly 38 cells long. While the chain is active, each `shift_dr` clock moves every cell one place toward `tdo`, so a bit entered on `tdi` appears on `tdo` after 38 shift clocks.
- R2: Field placement within the frame is fixed. The cell next to `tdi` is the direction bit. It is followed by index bits 4 down to 0, then data bits 0 up to 31, with data bit 31 in the last cell, which drives `tdo`. The first bit shifted out is therefore data bit 31, and the first bit shifted in lands in that same cell.
- R3: A `capture_dr` pulse leaves the chain and the register bank unchanged.
- R4: On an active `update_dr` with the direction bit at 1, the 32 data bits are written into the register at the 5-bit index. The chain contents stay unchanged.
- R5: On an active `update_dr` with the direction bit at 0, the indexed register's value is loaded into the data field. The direction and index cells keep their values. The loaded value is shifted out on the next shift pass.
- R6: Indices at or above `NUM_REGS` read back as zero, and writes to them are ignored.
- R7: Unless both `chain_sel` and `intest` are high, shift and update strobes have no effect. The chain, the bank and `tdo` hold their values.
- R8: An active-low `rst_n` clears the chain and every register, so `tdo` is 0 and every read returns zero.
- R9: A write changes only the register it addresses. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Capture strobe from the TAP controller (no effect) |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| chain_sel | input | 1 | High when this chain is the selected scan chain |
| intest | input | 1 | High when the TAP holds the internal-test instruction |
| tdo | output | 1 | Serial data out, the last chain cell |

## Verification
The bench builds the block with `NUM_REGS` set to 20. With 5 index bits, that leaves indices 20 to 31 unimplemented. Writes and reads at index 19, and at indices 20 and 31, exercise both sides of the implemented-range boundary. Single-bit data words at the two ends of the data field, together with a raw pass-through of one frame behind another, confirm the field order and the chain length. Frames sent while `chain_sel` or `intest` is low confirm that nothing is touched while the chain is inactive.

// File: rtl/dbg_regscan.sv
module dbg_regscan #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic chain_sel,
  input  logic intest,
  output logic tdo
);
  localparam int FRAME_W  = 1 + ADDR_W + DATA_W;
  localparam int RW_POS   = FRAME_W - 1;
  localparam int ADDR_LSB = DATA_W;

  logic [FRAME_W-1:0]               sr;
  logic [NUM_REGS-1:0][DATA_W-1:0]  bank;
  logic                             active;
  logic                             frm_rw;
  logic [ADDR_W-1:0]                frm_addr;
  logic [DATA_W-1:0]                frm_data;
  logic [DATA_W-1:0]                rd_data;
  logic [DATA_W-1:0]                rd_cells;

  assign active   = chain_sel & intest;
  assign frm_rw   = sr[RW_POS];
  assign frm_addr = sr[ADDR_LSB +: ADDR_W];
  assign tdo      = sr[0];

  // data bit i sits DATA_W-1-i cells from tdo
  for (genvar b = 0; b < DATA_W; b++) begin : g_bitmap
    assign frm_data[b]            = sr[DATA_W-1-b];
    assign rd_cells[DATA_W-1-b]   = rd_data[b];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (frm_addr == ADDR_W'(i)) rd_data = bank[i];
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
    end else if (active && update_dr && frm_rw) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (frm_addr == ADDR_W'(i)) bank[i] <= frm_data;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (active) begin
      if (update_dr) begin
        if (!frm_rw) sr[DATA_W-1:0] <= rd_cells;
      end else if (shift_dr) begin
        sr <= {tdi, sr[FRAME_W-1:1]};
      end
    end
  end

  AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!rst_n)
    active && shift_dr && !update_dr |=> (tdo == $past(sr[1])) && (sr[RW_POS] == $past(tdi))); // R1
  AST_CAPTURE_INERT: assert property (@(posedge tck) disable iff (!rst_n)
    active && capture_dr && !shift_dr && !update_dr |=> $stable(sr) && $stable(bank)); // R3
  AST_WRITE_KEEPS_FRAME: assert property (@(posedge tck) disable iff (!rst_n)
    active && update_dr && frm_rw |=> $stable(sr)); // R4
  AST_READ_KEEPS_HEADER: assert property (@(posedge tck) disable iff (!rst_n)
    active && update_dr && !frm_rw |=> $stable(sr[FRAME_W-1:DATA_W]) && $stable(bank)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
    active && update_dr && !frm_rw && (int'(frm_addr) >= NUM_REGS) |=> sr[DATA_W-1:0] == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    !active |=> $stable(sr) && $stable(bank) && $stable(tdo)); // R7
endmodule

// File: tb/dbg_regscan_bench.sv
`timescale 1ns/1ps
module dbg_regscan_bench;
  localparam int NR = 20;

  logic tck = 1'b0, rst_n = 1'b0, tdi = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic chain_sel = 1'b1, intest = 1'b1;
  logic tdo;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] model [32];
  logic [31:0] exp_q [$];
  logic [31:0] obs_q [$];
  string       tag_q [$];

  always #2.5 tck = ~tck;

  dbg_regscan #(.ADDR_W(5), .DATA_W(32), .NUM_REGS(NR)) u_dbg_regscan (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .chain_sel(chain_sel),
    .intest(intest), .tdo(tdo));

  // frame bit k is the k-th bit shifted in / out (R2 layout)
  function automatic logic [37:0] mk(input logic rw, input logic [4:0] a, input logic [31:0] d);
    logic [37:0] f;
    f[37] = rw;
    f[36:32] = a;
    for (int i = 0; i < 32; i++) f[31-i] = d[i];
    return f;
  endfunction

  function automatic logic [31:0] dat(input logic [37:0] f);
    logic [31:0] d;
    for (int i = 0; i < 32; i++) d[i] = f[31-i];
    return d;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_pass(input logic [37:0] fin, output logic [37:0] fout);
    for (int k = 0; k < 38; k++) begin
      @(negedge tck);
      fout[k] = tdo;
      tdi = fin[k];
      shift_dr = 1'b1;
    end
    @(negedge tck);
    shift_dr = 1'b0;
    tdi = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge tck); update_dr = 1'b1;
    @(negedge tck); update_dr = 1'b0;
  endtask

  task automatic pulse_capture();
    @(negedge tck); capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [37:0] o;
    shift_pass(mk(1'b1, a, d), o);
    pulse_update();
    if (a < NR) model[a] = d;
  endtask

  task automatic rd(input logic [4:0] a, input string tag, output logic [37:0] o2);
    logic [37:0] o;
    shift_pass(mk(1'b0, a, 32'h0), o);
    pulse_update();
    exp_q.push_back(a < NR ? model[a] : 32'h0);
    tag_q.push_back(tag);
    pulse_capture();
    shift_pass(mk(1'b0, 5'd0, 32'h0), o2);
    obs_q.push_back(dat(o2));
    check({tag, " R5 header"}, {58'h0, o2[37:32]}, {58'h0, 1'b0, a});
  endtask

  initial begin : monitor
    forever begin
      wait (obs_q.size() > 0);
      check(tag_q.pop_front(), {32'h0, obs_q.pop_front()}, {32'h0, exp_q.pop_front()});
    end
  end

  initial begin : main
    logic [37:0] o, oa, ob;
    logic held;
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    @(negedge tck);
    check("R8 tdo after reset", {63'h0, tdo}, 64'h0);
    rd(5'd3, "R8 reset read", o);

    wr(5'd0, 32'hA5A5_0001);
    wr(5'd7, 32'hDEAD_BEEF);
    wr(5'd19, 32'h1357_9BDF);
    wr(5'd20, 32'hFFFF_FFFF);
    wr(5'd31, 32'hCAFE_F00D);
    rd(5'd0, "R4 write idx0", o);
    rd(5'd7, "R4 write idx7", o);
    rd(5'd19, "R6 last implemented idx19", o);
    rd(5'd20, "R6 unmapped idx20", o);
    rd(5'd31, "R6 unmapped idx31", o);
    rd(5'd5, "R9 untouched idx5", o);

    wr(5'd1, 32'h0000_0001);
    wr(5'd2, 32'h8000_0000);
    rd(5'd1, "R2 data bit0", o);
    check("R2 bit0 is last data bit out", {63'h0, o[31]}, 64'h1);
    rd(5'd2, "R2 data bit31", o);
    check("R2 bit31 is first bit out", {63'h0, o[0]}, 64'h1);
    rd(5'd0, "R9 idx0 after other writes", o);

    // R4: chain unchanged by a write update
    shift_pass(mk(1'b1, 5'd9, 32'h0BAD_C0DE), o);
    pulse_update();
    model[9] = 32'h0BAD_C0DE;
    shift_pass(mk(1'b0, 5'd0, 32'h0), o);
    check("R4 chain kept after write", {26'h0, o}, {26'h0, mk(1'b1, 5'd9, 32'h0BAD_C0DE)});

    // R1: 38-cell pass-through
    oa = mk(1'b1, 5'd21, 32'h1234_5678);
    shift_pass(oa, o);
    shift_pass(mk(1'b0, 5'd0, 32'h0), ob);
    check("R1 frame length 38", {26'h0, ob}, {26'h0, oa});

    // R3: capture pulses do not disturb a loaded read value
    shift_pass(mk(1'b0, 5'd7, 32'h0), o);
    pulse_update();
    repeat (3) pulse_capture();
    shift_pass(mk(1'b0, 5'd0, 32'h0), o);
    check("R3 capture inert", {32'h0, dat(o)}, {32'h0, 32'hDEAD_BEEF});

    // R7: inactive chain ignores shift and update
    shift_pass(mk(1'b0, 5'd0, 32'h1), o);
    held = tdo;
    chain_sel = 1'b0;
    shift_pass(mk(1'b1, 5'd7, 32'h0), o);
    check("R7 tdo held (deselected)", {26'h0, o}, {26'h0, {38{held}}});
    pulse_update();
    chain_sel = 1'b1;
    intest = 1'b0;
    shift_pass(mk(1'b1, 5'd9, 32'h5555_AAAA), o);
    pulse_update();
    check("R7 tdo held (no intest)", {63'h0, tdo}, {63'h0, held});
    intest = 1'b1;
    rd(5'd7, "R7 idx7 unchanged", o);
    rd(5'd9, "R7 idx9 unchanged", o);

    wait (obs_q.size() == 0);
    @(negedge tck);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge tck);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule